// File: doc/BRIEF.md
# Multi-Rail Reset Sequencer with Margin Freeze

This block turns a set of per-rail undervoltage flags, an active-low manual reset, a watchdog timeout request, a lockout flag and an active-low margin-test request into one active-low system reset and one active-low fault line per rail. The comparators, thresholds and pad drivers sit outside. The block works only on digital flags.

Any rail below threshold, or a filtered manual reset, pulls the system reset low. The reset stays low for a programmable hold count after every cause has gone. A rising edge on the watchdog request forces one full hold period.

Margin test freezes every output. After a fixed delay it drives them all inactive, and it keeps them that way until a second delay has run out after margin ends. A watchdog timeout that arrives during margin is kept and fires when margin ends. The lockout flag overrides everything. All inputs are asynchronous and pass through synchronisers. One shared down-counter and a four-state sequencer time both the hold and the margin delays.

Top module: `rail_reset_ctrl`

## Requirements
- R1: When any bit of `rail_low_i` is 1 (rail below threshold), or the filtered manual reset is active, and neither margin nor lockout is in force, `sys_rst_n_o` is 0 from the third rising edge after the input change.
- R2: With hold count L, `sys_rst_n_o` rises on the (L+2)-th rising edge after the last cause clears, counting from the first edge after the change. A fault during the hold restarts this count from its own release.
- R3: `hold_cfg_i` = 0 selects the parameter `HOLD_DEFAULT` as L. Any nonzero value is used directly as L.
- R4: Outside margin and lockout, `rail_fault_n_o[i]` equals the inverse of `rail_low_i[i]` from the third edge on, whatever the reset output does.
- R5: A margin request (`margin_n_i` = 0) freezes both outputs at their current values through edge MARGIN_DLY+2. From edge MARGIN_DLY+3 on, it drives them all to 1 and holds them there whatever the rail flags do.
- R6: After `margin_n_i` returns to 1, all outputs stay 1 up to and including edge MARGIN_DLY+2. They are then evaluated again. With no cause pending, the reset stays high.
- R7: A watchdog request edge seen during margin is held. `sys_rst_n_o` falls on edge MARGIN_DLY+3 after margin release and then runs a full hold period.
- R8: While `uvlo_i` = 1, both outputs are all 0 from the third edge, even in margin. After lockout clears, the rail outputs show the true flags from the third edge, and the reset rises on edge L+2.
- R9: Manual-reset low pulses shorter than `MR_FILT` synchronised cycles have no effect. A pulse of exactly `MR_FILT` cycles asserts the reset.
- R10: Outside margin, a rising edge on `wdt_req_i` drives `sys_rst_n_o` low from the third edge through edge L+2, and high again on edge L+3.
- R11: While `rst_ni` is 0, `sys_rst_n_o` and every `rail_fault_n_o` bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rail_low_i | input | N | Per-rail undervoltage flags, 1 = below threshold |
| mr_n_i | input | 1 | Manual reset request, active low |
| wdt_req_i | input | 1 | Watchdog timeout request, acts on its rising edge |
| uvlo_i | input | 1 | Supply lockout flag, 1 = locked out |
| margin_n_i | input | 1 | Margin-test request, active low |
| hold_cfg_i | input | CNT_W | Hold count in cycles, 0 = use HOLD_DEFAULT |
| sys_rst_n_o | output | 1 | System reset, active low |
| rail_fault_n_o | output | N | Per-rail fault outputs, active low |

## Verification
The deferred watchdog is the hardest case to reach from the ports. The request edge has to land inside a margin window that has already locked, and the reset must then be seen staying high for exactly MARGIN_DLY+2 edges after release before it falls. The stimulus first waits out the margin entry delay and then pulses the watchdog. It releases margin on a known negative edge and samples the two edges around the expected fall. The frozen state during margin entry is reached the same way. A rail fault is held, then margin is requested while the rail pattern changes in the same cycle, and the old pattern must persist until the entry delay runs out.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_MLOCK = 2'd2,
      ST_MEXIT = 2'd3
   } rrc_state_e;
endpackage

// File: rtl/rrc_sync.sv
module rrc_sync #(
   parameter int unsigned W = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      end else begin
         pipe[0] <= d_i;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rrc_deglitch.sv
module rrc_deglitch #(
   parameter int unsigned FILT = 4,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic filt_o
);
   generate
      if (FILT <= 1) begin : g_pass
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) filt_o <= RST_VAL;
            else         filt_o <= raw_i;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT);
         localparam logic [CW-1:0] LAST = CW'(FILT - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               filt_o <= RST_VAL;
               run_q  <= '0;
            end else if (raw_i == filt_o) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               filt_o <= raw_i;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rrc_seq.sv
module rrc_seq
   import rrc_pkg::*;
#(
   parameter int unsigned N = 4,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned MARGIN_DLY = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     rail_low_i,
   input  logic             mr_act_i,
   input  logic             uv_i,
   input  logic             mg_i,
   input  logic             wd_evt_i,
   input  logic [CNT_W-1:0] hold_len_i,
   output logic             sys_rst_n_o,
   output logic [N-1:0]     rail_n_o,
   output rrc_state_e       state_o
);
   localparam logic [CNT_W-1:0] MDLY = CNT_W'(MARGIN_DLY - 1);

   rrc_state_e       st_q, st_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             pend_q, pend_n;
   logic             rst_q, rst_n;
   logic [N-1:0]     rail_q, rail_n;
   logic             fault;
   logic [CNT_W-1:0] reload;

   assign fault  = (|rail_low_i) | mr_act_i;
   assign reload = hold_len_i - 1'b1;

   always_comb begin
      st_n   = st_q;
      cnt_n  = cnt_q;
      pend_n = pend_q;
      rst_n  = rst_q;
      rail_n = rail_q;
      if (uv_i) begin
         st_n   = ST_HOLD;
         cnt_n  = reload;
         pend_n = 1'b0;
         rst_n  = 1'b0;
         rail_n = '0;
      end else begin
         unique case (st_q)
            ST_IDLE, ST_HOLD: begin
               if (mg_i) begin
                  st_n   = ST_MLOCK;
                  cnt_n  = MDLY;
                  pend_n = wd_evt_i;
               end else begin
                  rail_n = ~rail_low_i;
                  if (fault || wd_evt_i) begin
                     st_n  = ST_HOLD;
                     cnt_n = reload;
                     rst_n = 1'b0;
                  end else if (st_q == ST_HOLD && cnt_q != '0) begin
                     cnt_n = cnt_q - 1'b1;
                     rst_n = 1'b0;
                  end else begin
                     st_n  = ST_IDLE;
                     rst_n = 1'b1;
                  end
               end
            end
            ST_MLOCK: begin
               pend_n = pend_q | wd_evt_i;
               if (!mg_i) begin
                  st_n   = ST_MEXIT;
                  cnt_n  = MDLY;
                  rst_n  = 1'b1;
                  rail_n = '1;
               end else if (cnt_q != '0) begin
                  cnt_n = cnt_q - 1'b1;
               end else begin
                  rst_n  = 1'b1;
                  rail_n = '1;
               end
            end
            ST_MEXIT: begin
               pend_n = pend_q | wd_evt_i;
               rst_n  = 1'b1;
               rail_n = '1;
               if (mg_i) begin
                  st_n  = ST_MLOCK;
                  cnt_n = '0;
               end else if (cnt_q != '0) begin
                  cnt_n = cnt_q - 1'b1;
               end else begin
                  pend_n = 1'b0;
                  rail_n = ~rail_low_i;
                  if (pend_q || wd_evt_i || fault) begin
                     st_n  = ST_HOLD;
                     cnt_n = reload;
                     rst_n = 1'b0;
                  end else begin
                     st_n = ST_IDLE;
                  end
               end
            end
            default: st_n = ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_HOLD;
         cnt_q  <= '0;
         pend_q <= 1'b0;
         rst_q  <= 1'b0;
         rail_q <= '0;
      end else begin
         st_q   <= st_n;
         cnt_q  <= cnt_n;
         pend_q <= pend_n;
         rst_q  <= rst_n;
         rail_q <= rail_n;
      end
   end

   assign sys_rst_n_o = rst_q;
   assign rail_n_o    = rail_q;
   assign state_o     = st_q;
endmodule

// File: rtl/rail_reset_ctrl.sv
module rail_reset_ctrl
   import rrc_pkg::*;
#(
   parameter int unsigned N = 4,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned HOLD_DEFAULT = 28000000,
   parameter int unsigned MARGIN_DLY = 10000,
   parameter int unsigned MR_FILT = 20,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N-1:0]     rail_low_i,
   input  logic             mr_n_i,
   input  logic             wdt_req_i,
   input  logic             uvlo_i,
   input  logic             margin_n_i,
   input  logic [CNT_W-1:0] hold_cfg_i,
   output logic             sys_rst_n_o,
   output logic [N-1:0]     rail_fault_n_o
);
   localparam logic [CNT_W-1:0] HOLD_DEF_V = CNT_W'(HOLD_DEFAULT);
   localparam logic [3:0] CTL_RST = 4'b1101;

   if (N < 1) begin : g_bad_n
      $error("rail_reset_ctrl: N must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("rail_reset_ctrl: CNT_W out of range 2..32");
   end
   if (HOLD_DEFAULT < 1 || MARGIN_DLY < 1) begin : g_bad_dly
      $error("rail_reset_ctrl: delays must be at least one cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rail_reset_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N-1:0]     rl_s;
   logic [3:0]       ctl_s;
   logic             mr_raw, mr_filt, mr_act;
   logic             wd_s, wd_d, wd_evt;
   logic             uv_s, mg_s;
   logic [CNT_W-1:0] hold_len;
   rrc_state_e       state_w;

   rrc_sync #(.W(N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rail_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rail_low_i), .q_o(rl_s));

   rrc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .d_i({margin_n_i, uvlo_i, wdt_req_i, mr_n_i}), .q_o(ctl_s));

   assign mr_raw = ctl_s[0];
   assign wd_s   = ctl_s[1];
   assign uv_s   = ctl_s[2];
   assign mg_s   = ~ctl_s[3];

   rrc_deglitch #(.FILT(MR_FILT), .RST_VAL(1'b1)) u_mr_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(mr_raw), .filt_o(mr_filt));

   assign mr_act = ~mr_filt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wd_d <= 1'b0;
      else         wd_d <= wd_s;
   end
   assign wd_evt = wd_s & ~wd_d;

   assign hold_len = (hold_cfg_i == '0) ? HOLD_DEF_V : hold_cfg_i;

   rrc_seq #(.N(N), .CNT_W(CNT_W), .MARGIN_DLY(MARGIN_DLY)) u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni), .rail_low_i(rl_s), .mr_act_i(mr_act),
      .uv_i(uv_s), .mg_i(mg_s), .wd_evt_i(wd_evt), .hold_len_i(hold_len),
      .sys_rst_n_o(sys_rst_n_o), .rail_n_o(rail_fault_n_o), .state_o(state_w));
endmodule

// File: rtl/rail_reset_ctrl_chk.sv
module rail_reset_ctrl_chk
   import rrc_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic [N-1:0] rl_s,
   input logic         mr_act,
   input logic         mr_raw,
   input logic         mr_filt,
   input logic         uv_s,
   input logic         mg_s,
   input logic         wd_evt,
   input rrc_state_e   state_w,
   input logic         sys_rst_n_o,
   input logic [N-1:0] rail_fault_n_o
);
   logic normal;
   assign normal = (state_w == ST_IDLE) || (state_w == ST_HOLD);

   assert_fault_asserts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!uv_s && !mg_s && normal && ((|rl_s) || mr_act)) |=> !sys_rst_n_o);

   assert_rail_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!uv_s && !mg_s && normal) |=> (rail_fault_n_o == ~$past(rl_s)));

   assert_margin_keeps_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mg_s && !uv_s && sys_rst_n_o && (&rail_fault_n_o)) |=>
      (sys_rst_n_o && (&rail_fault_n_o)));

   assert_exit_outputs_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_w == ST_MEXIT) |-> (sys_rst_n_o && (&rail_fault_n_o)));

   assert_lockout_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_s |=> (!sys_rst_n_o && (rail_fault_n_o == '0)));

   assert_mr_filter_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mr_raw == mr_filt) |=> $stable(mr_filt));

   assert_wdt_asserts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wd_evt && !uv_s && !mg_s && normal) |=> !sys_rst_n_o);
endmodule

bind rail_reset_ctrl rail_reset_ctrl_chk #(.N(N)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .rl_s(rl_s), .mr_act(mr_act),
   .mr_raw(mr_raw), .mr_filt(mr_filt), .uv_s(uv_s), .mg_s(mg_s),
   .wd_evt(wd_evt), .state_w(state_w), .sys_rst_n_o(sys_rst_n_o),
   .rail_fault_n_o(rail_fault_n_o));

// File: tb/rail_reset_ctrl_test.sv
`timescale 1ns/1ps
module rail_reset_ctrl_test;
   localparam int NR = 4;
   localparam int HDEF = 40;
   localparam int MD = 6;
   localparam int MF = 4;

   logic          clk_i = 1'b0;
   logic          rst_ni;
   logic [NR-1:0] rail_low_i;
   logic          mr_n_i, wdt_req_i, uvlo_i, margin_n_i;
   logic [31:0]   hold_cfg_i;
   logic          sys_rst_n_o;
   logic [NR-1:0] rail_fault_n_o;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2.5 clk_i = ~clk_i;

   rail_reset_ctrl #(.N(NR), .CNT_W(32), .HOLD_DEFAULT(HDEF), .MARGIN_DLY(MD),
                     .MR_FILT(MF), .SYNC_STAGES(2)) uut (
      .clk_i(clk_i), .rst_ni(rst_ni), .rail_low_i(rail_low_i), .mr_n_i(mr_n_i),
      .wdt_req_i(wdt_req_i), .uvlo_i(uvlo_i), .margin_n_i(margin_n_i),
      .hold_cfg_i(hold_cfg_i), .sys_rst_n_o(sys_rst_n_o),
      .rail_fault_n_o(rail_fault_n_o));

   function automatic logic [NR-1:0] exp_rails(input logic [NR-1:0] low);
      return ~low;
   endfunction

   function automatic int eff_hold(input logic [31:0] cfg);
      return (cfg == 0) ? HDEF : int'(cfg);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // after a release at the current negedge: low through edge L+1, high on edge L+2
   task automatic expect_release(input int L, input string req);
      tick(L + 1);
      chk(req, {31'd0, sys_rst_n_o}, 32'd0);
      tick(1);
      chk(req, {31'd0, sys_rst_n_o}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      logic [NR-1:0] pat;
      int L;
      void'($urandom(32'h1A2B3C));
      rst_ni = 1'b0; rail_low_i = '0; mr_n_i = 1'b1; wdt_req_i = 1'b0;
      uvlo_i = 1'b0; margin_n_i = 1'b1; hold_cfg_i = 32'd0;
      tick(3);
      // R11 reset state
      chk("R11", {31'd0, sys_rst_n_o}, 32'd0);
      chk("R11", {28'd0, rail_fault_n_o}, 32'd0);
      rst_ni = 1'b1;
      tick(60);
      chk("R11", {31'd0, sys_rst_n_o}, 32'd1);

      // R3 default hold via cfg 0, R1 and R4 on the way
      rail_low_i = 4'b0010;
      tick(4);
      chk("R1", {31'd0, sys_rst_n_o}, 32'd0);
      chk("R4", {28'd0, rail_fault_n_o}, {28'd0, exp_rails(4'b0010)});
      rail_low_i = '0;
      expect_release(eff_hold(hold_cfg_i), "R3");

      // R2 restart of the hold by a one-cycle fault
      hold_cfg_i = 32'd12;
      rail_low_i = 4'b0001;
      tick(4);
      rail_low_i = '0;
      tick(5);
      chk("R2", {31'd0, sys_rst_n_o}, 32'd0);
      rail_low_i = 4'b1000;
      tick(1);
      rail_low_i = '0;
      expect_release(12, "R2");

      // R10 watchdog outside margin, L = 10
      hold_cfg_i = 32'd10;
      tick(3);
      wdt_req_i = 1'b1;
      tick(2);
      chk("R10", {31'd0, sys_rst_n_o}, 32'd1);
      tick(1);
      chk("R10", {31'd0, sys_rst_n_o}, 32'd0);
      wdt_req_i = 1'b0;
      tick(10 - 1);
      chk("R10", {31'd0, sys_rst_n_o}, 32'd0);
      tick(1);
      chk("R10", {31'd0, sys_rst_n_o}, 32'd1);

      // R9 manual reset glitch of MF-1 cycles ignored
      mr_n_i = 1'b0;
      tick(MF - 1);
      mr_n_i = 1'b1;
      for (int k = 0; k < 12; k++) begin
         chk("R9", {31'd0, sys_rst_n_o}, 32'd1);
         tick(1);
      end
      // pulse of exactly MF cycles accepted
      mr_n_i = 1'b0;
      tick(MF);
      mr_n_i = 1'b1;
      tick(3);
      chk("R9", {31'd0, sys_rst_n_o}, 32'd0);
      tick(30);
      chk("R9", {31'd0, sys_rst_n_o}, 32'd1);

      // R5 freeze on entry, then forced high
      rail_low_i = 4'b0001;
      tick(4);
      margin_n_i = 1'b0;
      rail_low_i = 4'b0100;
      tick(MD + 2);
      chk("R5", {31'd0, sys_rst_n_o}, 32'd0);
      chk("R5", {28'd0, rail_fault_n_o}, {28'd0, exp_rails(4'b0001)});
      tick(1);
      chk("R5", {31'd0, sys_rst_n_o}, 32'd1);
      chk("R5", {28'd0, rail_fault_n_o}, 32'hF);
      for (int k = 0; k < 8; k++) begin
         rail_low_i = 4'($urandom);
         tick(3);
         chk("R5", {27'd0, sys_rst_n_o, rail_fault_n_o}, 32'h1F);
      end

      // R7 deferred watchdog, R6 exit delay
      rail_low_i = '0;
      wdt_req_i = 1'b1;
      tick(3);
      wdt_req_i = 1'b0;
      tick(3);
      chk("R7", {31'd0, sys_rst_n_o}, 32'd1);
      margin_n_i = 1'b1;
      tick(MD + 2);
      chk("R6", {27'd0, sys_rst_n_o, rail_fault_n_o}, 32'h1F);
      tick(1);
      chk("R7", {31'd0, sys_rst_n_o}, 32'd0);
      chk("R7", {28'd0, rail_fault_n_o}, 32'hF);
      tick(15);
      chk("R7", {31'd0, sys_rst_n_o}, 32'd1);

      // R6 exit with nothing pending leaves reset high
      margin_n_i = 1'b0;
      tick(MD + 5);
      margin_n_i = 1'b1;
      tick(MD + 6);
      chk("R6", {31'd0, sys_rst_n_o}, 32'd1);

      // R8 lockout overrides margin, then rails recover and hold runs
      margin_n_i = 1'b0;
      tick(MD + 5);
      uvlo_i = 1'b1;
      tick(3);
      chk("R8", {27'd0, sys_rst_n_o, rail_fault_n_o}, 32'h0);
      uvlo_i = 1'b0;
      margin_n_i = 1'b1;
      tick(3);
      chk("R8", {28'd0, rail_fault_n_o}, 32'hF);
      chk("R8", {31'd0, sys_rst_n_o}, 32'd0);
      tick(10 - 2);
      chk("R8", {31'd0, sys_rst_n_o}, 32'd0);
      tick(1);
      chk("R8", {31'd0, sys_rst_n_o}, 32'd1);

      // constrained random: rail patterns and hold counts
      for (int it = 0; it < 24; it++) begin
         L = 2 + int'($urandom % 10);
         hold_cfg_i = 32'(L);
         pat = 4'($urandom);
         rail_low_i = pat;
         tick(4);
         chk("R4", {28'd0, rail_fault_n_o}, {28'd0, exp_rails(pat)});
         chk("R1", {31'd0, sys_rst_n_o}, {31'd0, (pat == '0)});
         rail_low_i = '0;
         if (pat != '0) expect_release(L, "R2");
         else tick(2);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule